// File: doc/BRIEF.md
# Fill-Level QoS Priority Mapper

This block sits in the inbound path of a bridge that turns serial-link requests into AXI transactions. It produces a 4-bit AXI QoS value for the requests of each of eight traffic classes. By default, the value for a class is taken from a 16-bit map word for that class. The map word holds one nibble for each quarter of fill of that class's request queue, so a class whose queue backs up can be given more urgency.

Message mode is an alternative. A received priority message carries a 4-bit index and a traffic class. When the enable bit is set, the index is stored for that class, and the class then takes its QoS from a shared 16-entry nibble table until a newer message arrives. Software sets up the maps, the table and the enable bit with single-cycle register writes.

The occupancy inputs and the message strobe are sampled in every cycle. A message is a one-cycle strobe with no ready signal, so the block never applies back-pressure.

Top module: `qos_level_mapper`

## Requirements
- R1: While reset is asserted, and after it is released, every QoS output is 0, every map word and table word is 0, the enable bit is clear and no class holds a message index.
- R2: Let D be the queue depth. The fill quarter of a class is 0 for occupancy below D/4, 1 for occupancy below D/2, 2 for occupancy below 3D/4, and 3 for any larger occupancy, including an occupancy of D or more. Quarter q selects bits 4q+3:4q of the map word.
- R3: Each class uses only its own map word and its own occupancy input. Occupancy input t is bits 5t+4:5t, and QoS output t is bits 4t+3:4t.
- R4: A write to address t (0 to 7) loads bits 15:0 of the data into the map word of class t. Address 8 loads the low table word, address 9 loads the high table word, and bit 0 of a write to address 10 sets the enable bit. Writes to addresses 11 to 15 change nothing.
- R5: Table entry x (0 to 15) is bits 4x+3:4x of the low word when x is below 8. Otherwise it is bits 4(x-8)+3:4(x-8) of the high word.
- R6: When the enable bit is clear, a message is not stored, and the QoS of every class keeps following its map word.
- R7: When the enable bit is set, a message for class t stores its index. From then on, class t takes its QoS from the table entry at that index, whatever its occupancy, until the next message for class t.
- R8: Clearing the enable bit discards every stored index. Every class then returns to its map word and stays there until it receives a new message with the enable bit set.
- R9: The QoS outputs are registered. A change of occupancy appears on the output after the next clock edge. A register write or a message appears one edge later, because it is first stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| occ_i | input | 40 | Queue occupancy, 5 bits per class |
| msg_valid | input | 1 | Priority message strobe |
| msg_tc | input | 3 | Traffic class of the message |
| msg_idx | input | 4 | Table index carried by the message |
| qos_o | output | 32 | QoS value, 4 bits per class |

## Verification
A change of occupancy shows on the QoS output after one clock edge. A register write or a message takes two edges: one edge to store it, and a second edge for the output register to use it. The bench model follows the same rule. At each rising edge it computes the expected output from the state it held before that edge, and only then applies the writes and messages of that cycle. The bench compares the DUT output with this expectation at the following falling edge, so a result that arrives a cycle early or a cycle late is reported.

// File: rtl/qlm_pkg.sv
package qlm_pkg;
  localparam int QOS_W   = 4;
  localparam int MAP_W   = 4 * QOS_W;
  localparam int NMSG    = 16;
  localparam int TBL_W   = NMSG * QOS_W;
  typedef logic [QOS_W-1:0] qos_t;
  typedef logic [1:0]       quart_t;
endpackage

// File: rtl/qlm_cfg_regs.sv
module qlm_cfg_regs
  import qlm_pkg::*;
#(
  parameter int NUM_TC = 8,
  parameter int AW     = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [AW-1:0]           addr,
  input  logic [31:0]             wdata,
  output logic [NUM_TC*MAP_W-1:0] map_flat,
  output logic [TBL_W-1:0]        tbl,
  output logic                    en
);
  localparam int A_LO   = NUM_TC;
  localparam int A_HI   = NUM_TC + 1;
  localparam int A_CTRL = NUM_TC + 2;

  for (genvar t = 0; t < NUM_TC; t++) begin : g_map
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) map_flat[t*MAP_W +: MAP_W] <= '0;
      else if (we && addr == AW'(t)) map_flat[t*MAP_W +: MAP_W] <= wdata[MAP_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl <= '0;
      en  <= 1'b0;
    end else if (we) begin
      if (addr == AW'(A_LO))   tbl[31:0]  <= wdata;
      if (addr == AW'(A_HI))   tbl[63:32] <= wdata;
      if (addr == AW'(A_CTRL)) en         <= wdata[0];
    end
  end
endmodule

// File: rtl/qlm_quartile.sv
module qlm_quartile
  import qlm_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic [OCC_W-1:0] occ,
  output quart_t           quart
);
  localparam int LOGD = $clog2(DEPTH);

  always_comb begin
    if (occ >= OCC_W'(DEPTH)) quart = 2'd3;
    else                      quart = occ[LOGD-1 -: 2];
  end
endmodule

// File: rtl/qlm_msg_track.sv
module qlm_msg_track
  import qlm_pkg::*;
#(
  parameter int NUM_TC = 8,
  parameter int TC_W   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    msg_valid,
  input  logic [TC_W-1:0]         msg_tc,
  input  logic [3:0]              msg_idx,
  output logic [NUM_TC-1:0]       held,
  output logic [NUM_TC*4-1:0]     idx_flat
);
  for (genvar t = 0; t < NUM_TC; t++) begin : g_trk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        held[t]            <= 1'b0;
        idx_flat[t*4 +: 4] <= '0;
      end else if (!en) begin
        held[t] <= 1'b0;
      end else if (msg_valid && msg_tc == TC_W'(t)) begin
        held[t]            <= 1'b1;
        idx_flat[t*4 +: 4] <= msg_idx;
      end
    end
  end
endmodule

// File: rtl/qos_level_mapper.sv
module qos_level_mapper
  import qlm_pkg::*;
#(
  parameter int NUM_TC = 8,
  parameter int DEPTH  = 16,
  localparam int OCC_W  = $clog2(DEPTH + 1),
  localparam int TC_W   = $clog2(NUM_TC),
  localparam int CFG_AW = $clog2(NUM_TC + 3)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [CFG_AW-1:0]        cfg_addr,
  input  logic [31:0]              cfg_wdata,
  input  logic [NUM_TC*OCC_W-1:0]  occ_i,
  input  logic                     msg_valid,
  input  logic [TC_W-1:0]          msg_tc,
  input  logic [3:0]               msg_idx,
  output logic [NUM_TC*QOS_W-1:0]  qos_o
);
  logic [NUM_TC*MAP_W-1:0] map_flat;
  logic [TBL_W-1:0]        tbl;
  logic                    ctrl_en;
  logic [NUM_TC-1:0]       held_vec;
  logic [NUM_TC*4-1:0]     idx_flat;

  qlm_cfg_regs #(.NUM_TC(NUM_TC), .AW(CFG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .map_flat(map_flat), .tbl(tbl), .en(ctrl_en)
  );

  qlm_msg_track #(.NUM_TC(NUM_TC), .TC_W(TC_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .msg_valid(msg_valid),
    .msg_tc(msg_tc), .msg_idx(msg_idx), .held(held_vec), .idx_flat(idx_flat)
  );

  for (genvar t = 0; t < NUM_TC; t++) begin : g_tc
    quart_t q;
    qos_t   qos_d;

    qlm_quartile #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_q (
      .occ(occ_i[t*OCC_W +: OCC_W]), .quart(q)
    );

    always_comb begin
      if (ctrl_en && held_vec[t]) qos_d = tbl[4*idx_flat[t*4 +: 4] +: QOS_W];
      else                        qos_d = map_flat[t*MAP_W + 4*q +: QOS_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) qos_o[t*QOS_W +: QOS_W] <= '0;
      else        qos_o[t*QOS_W +: QOS_W] <= qos_d;
    end
  end
endmodule

// File: rtl/qlm_chk.sv
module qlm_chk #(
  parameter int NUM_TC = 8,
  parameter int DEPTH  = 16,
  parameter int OCC_W  = $clog2(DEPTH + 1),
  parameter int TC_W   = $clog2(NUM_TC)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_TC*OCC_W-1:0] occ,
  input logic                    msg_valid,
  input logic [TC_W-1:0]         msg_tc,
  input logic [3:0]              msg_idx,
  input logic [NUM_TC*4-1:0]     qos,
  input logic                    en,
  input logic [NUM_TC-1:0]       held,
  input logic [NUM_TC*4-1:0]     idx_flat,
  input logic [NUM_TC*16-1:0]    map_flat
);
  p_full_quart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(en && held[0]) && occ[OCC_W-1:0] >= OCC_W'(DEPTH)) |=> (qos[3:0] == $past(map_flat[15:12])));

  p_empty_quart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(en && held[0]) && occ[OCC_W-1:0] == '0) |=> (qos[3:0] == $past(map_flat[3:0])));

  p_msg_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && msg_valid && msg_tc == '0) |=> (held[0] && idx_flat[3:0] == $past(msg_idx)));

  p_drop_on_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> (held == '0));

  p_held_only_by_msg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !msg_valid) |=> $stable(held));
endmodule

bind qos_level_mapper qlm_chk #(.NUM_TC(NUM_TC), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .occ(occ_i), .msg_valid(msg_valid), .msg_tc(msg_tc),
  .msg_idx(msg_idx), .qos(qos_o), .en(ctrl_en), .held(held_vec),
  .idx_flat(idx_flat), .map_flat(map_flat)
);

// File: tb/qos_level_mapper_tb.sv
module qos_level_mapper_tb;
  localparam int NTC = 8;
  localparam int D   = 16;
  localparam int OW  = 5;

  logic clk = 0;
  logic rst_n = 0;
  logic cfg_we = 0;
  logic [3:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [OW-1:0] occ_a [NTC];
  logic [NTC*OW-1:0] occ_flat;
  logic msg_valid = 0;
  logic [2:0] msg_tc = '0;
  logic [3:0] msg_idx = '0;
  logic [NTC*4-1:0] qos_o;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  for (genvar t = 0; t < NTC; t++) begin : g_occ
    assign occ_flat[t*OW +: OW] = occ_a[t];
  end

  qos_level_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .occ_i(occ_flat), .msg_valid(msg_valid),
    .msg_tc(msg_tc), .msg_idx(msg_idx), .qos_o(qos_o)
  );

  // Behavioural reference model
  logic [15:0] m_map [NTC];
  logic [31:0] m_lo, m_hi;
  bit          m_en;
  bit          m_held [NTC];
  logic [3:0]  m_idx [NTC];
  logic [3:0]  exp_q [NTC];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lo = '0; m_hi = '0; m_en = 0;
      for (int t = 0; t < NTC; t++) begin
        m_map[t] = '0; m_held[t] = 0; m_idx[t] = '0; exp_q[t] <= '0;
      end
    end else begin
      for (int t = 0; t < NTC; t++) begin
        int q;
        int x;
        q = (int'(occ_a[t]) * 4) / D;
        if (q > 3) q = 3;
        x = int'(m_idx[t]);
        if (m_en && m_held[t])
          exp_q[t] <= (x < 8) ? m_lo[4*x +: 4] : m_hi[4*(x-8) +: 4];
        else
          exp_q[t] <= m_map[t][4*q +: 4];
      end
      if (!m_en) begin
        for (int t = 0; t < NTC; t++) m_held[t] = 0;
      end else if (msg_valid) begin
        m_held[msg_tc] = 1; m_idx[msg_tc] = msg_idx;
      end
      if (cfg_we) begin
        if (cfg_addr < 8)        m_map[cfg_addr[2:0]] = cfg_wdata[15:0];
        else if (cfg_addr == 8)  m_lo = cfg_wdata;
        else if (cfg_addr == 9)  m_hi = cfg_wdata;
        else if (cfg_addr == 10) m_en = cfg_wdata[0];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int t = 0; t < NTC; t++) begin
        checks++;
        if (qos_o[4*t +: 4] !== exp_q[t]) begin
          errors++;
          $display("FAIL %s (R9 timing) tc%0d: actual %h expected %h", cur_req, t, qos_o[4*t +: 4], exp_q[t]);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic msg(input logic [2:0] tc, input logic [3:0] idx);
    msg_valid = 1; msg_tc = tc; msg_idx = idx;
    @(negedge clk);
    msg_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int t = 0; t < NTC; t++) occ_a[t] = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (qos_o !== '0) begin
      errors++;
      $display("FAIL R1 reset: actual %h expected 0", qos_o);
    end
    rst_n = 1;
    idle(3);

    cur_req = "R4";
    for (int t = 0; t < NTC; t++)
      wr(4'(t), {16'hDEAD, 4'(15 - t), 4'(t + 8), 4'(t + 3), 4'(t)});
    wr(4'd11, 32'hFFFF_FFFF);
    wr(4'd15, 32'h1);
    idle(3);

    cur_req = "R2";
    for (int o = 0; o <= D + 2 && o < 32; o++) begin
      occ_a[0] = 5'(o); idle(2);
    end

    cur_req = "R3";
    for (int k = 0; k < 20; k++) begin
      for (int t = 0; t < NTC; t++) occ_a[t] = 5'((k * 3 + t * 5) % (D + 1));
      idle(1);
    end

    cur_req = "R6";
    wr(4'd8, 32'h7654_3210 ^ 32'h5A5A_5A5A);
    wr(4'd9, 32'hFEDC_BA98);
    msg(3'd2, 4'd9);
    msg(3'd0, 4'd1);
    idle(4);

    cur_req = "R7";
    wr(4'd10, 32'h1);
    idle(2);
    for (int x = 0; x < 16; x++) begin
      msg(3'(x % NTC), 4'(x));
      occ_a[x % NTC] = 5'((x * 7) % (D + 1));
      idle(1);
    end
    for (int t = 0; t < NTC; t++) begin
      occ_a[t] = 5'(D); idle(1);
    end

    cur_req = "R5";
    wr(4'd8, 32'h1357_9BDF);
    idle(2);
    wr(4'd9, 32'h2468_ACE0);
    idle(3);

    cur_req = "R8";
    msg(3'd5, 4'd3);
    wr(4'd10, 32'h0);
    msg(3'd6, 4'd12);
    idle(4);
    wr(4'd10, 32'h1);
    idle(3);
    msg(3'd6, 4'd12);
    idle(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule